// File: doc/BRIEF.md
# Overtemperature Fan Boost Controller

This block sits between a fan speed policy and the PWM generators. It watches three 8-bit temperature channels. Each channel has its own trip limit and its own hysteresis. When an enabled channel has tripped, every fan duty output is driven to that fan's own programmed maximum. While no enabled channel is tripped, the requested duties pass straight through.

Each channel has a trip latch. The latch sets when a new reading is above the limit. It clears only when a reading falls below the limit minus the hysteresis, so the fans do not chatter near the threshold. The latch changes only when its channel's update strobe is high.

Temperature codes come in one of two encodings, chosen by a single input:
- Offset-64: the code is the temperature plus 64.
- Two's complement: the code is the signed temperature.

Each encoding has one limit code that switches its channel off. That code is also the lowest code of the encoding, which is the code a failed sensor reports.

Top module: `ovb_top`

## Requirements
- R1: While rst_ni is low, trip_o is 000 and each fan's duty_o slice equals its duty_req_i slice. This holds even if a trip had been latched before reset.
- R2: While no latched channel is enabled, each 8-bit slice k of duty_o equals slice k of duty_req_i. Slice k is bits [8k+7:8k], and channel c of the other vectors uses bit c or its slice at 8c or 4c.
- R3: On a clock edge where temp_vld_i[c] is high and the channel's temperature is strictly above its limit, trip_o[c] becomes 1 after that edge. From then on, while boosting is allowed, every duty_o slice equals the matching duty_max_i slice.
- R4: A temperature equal to the limit does not set trip_o[c].
- R5: A set trip_o[c] stays set while the strobed temperature is at or above the limit minus hyst_i[c] (in 1 °C steps). It clears on the first strobed reading strictly below that value. A hysteresis of 0 releases just below the limit.
- R6: trip_o[c] changes only on an edge where temp_vld_i[c] is high. Strobes and readings on other channels leave it unchanged.
- R7: With fmt_twos_i = 0 (offset-64), codes are compared unsigned, so 0xC0 is above a limit of 0x64.
- R8: With fmt_twos_i = 1 (two's complement), codes are compared signed. 0xF0 (−16) is not above 0x64, 0x70 is above it, and 0xFF (−1) is below a release value of 0x60.
- R9: With fmt_twos_i = 0, a limit code of 0x00 takes its channel out of the boost condition at once. The next strobe on that channel clears trip_o[c].
- R10: With fmt_twos_i = 1, a limit code of 0x80 disables the channel in the same way as R9. A strobed 0x7F then leaves trip_o[c] clear.
- R11: The release value saturates at the lowest code of the encoding instead of wrapping: 0x00 for offset-64 and 0x80 for two's complement. A tripped channel whose limit is less than hyst_i above the lowest code therefore stays tripped, even for a reading of that lowest code.
- R12: With boost_dis_i = 1, duty_o equals duty_req_i whatever trip_o holds. The latches keep updating.
- R13: A channel whose ch_mask_i bit is 1 still updates trip_o[c] but does not force the duties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_twos_i | input | 1 | Encoding select: 0 offset-64, 1 two's complement |
| boost_dis_i | input | 1 | Global boost disable |
| ch_mask_i | input | 3 | Per-channel boost mask, 1 = channel ignored |
| temp_i | input | 24 | Temperature code of channel c at [8c+7:8c] |
| temp_vld_i | input | 3 | Per-channel update strobe |
| limit_i | input | 24 | Trip limit code of channel c at [8c+7:8c] |
| hyst_i | input | 12 | Hysteresis of channel c at [4c+3:4c], in °C |
| duty_req_i | input | 24 | Requested duty of fan k at [8k+7:8k] |
| duty_max_i | input | 24 | Maximum duty of fan k at [8k+7:8k] |
| duty_o | output | 24 | Final duty of fan k at [8k+7:8k] |
| trip_o | output | 3 | Per-channel trip latch state |

## Verification
The hardest state to reach is a tripped channel whose limit lies within one hysteresis step of the lowest code. Only that state shows whether the release value saturates or wraps. The stimulus first moves the limit to 0x02 (offset-64) or 0x82 (two's complement) with a hysteresis of 5. It then trips the channel with a reading just above that limit, and finally strobes the lowest code, which a failed sensor reports. The encoding check also needs a reading whose order flips between signed and unsigned comparison, such as 0xF0 or 0xFF against 0x64.

// File: rtl/ovb_pkg.sv
package ovb_pkg;

  typedef enum logic {
    FMT_OFS64 = 1'b0,
    FMT_TWOS  = 1'b1
  } tfmt_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } trip_act_e;

endpackage

// File: rtl/ovb_chan.sv
module ovb_chan
  import ovb_pkg::*;
#(
  parameter int TW = 8,
  parameter int HW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  tfmt_e         fmt_i,
  input  logic [TW-1:0] temp_i,
  input  logic          vld_i,
  input  logic [TW-1:0] limit_i,
  input  logic [HW-1:0] hyst_i,
  output logic          armed_o,
  output logic          trip_o
);

  // flipping the sign bit maps signed codes onto the unsigned order
  localparam logic [TW-1:0] SIGN_FLIP = {1'b1, {(TW-1){1'b0}}};

  logic [TW-1:0] temp_key, lim_key, hyst_ext, rel_key;
  trip_act_e     act;
  logic          trip_q;

  always_comb begin
    temp_key = (fmt_i == FMT_TWOS) ? (temp_i ^ SIGN_FLIP) : temp_i;
    lim_key  = (fmt_i == FMT_TWOS) ? (limit_i ^ SIGN_FLIP) : limit_i;
    hyst_ext = TW'(hyst_i);
    // saturate release at the lowest code (key 0)
    rel_key  = (lim_key >= hyst_ext) ? (lim_key - hyst_ext) : '0;
    armed_o  = (lim_key != '0);
  end

  always_comb begin
    if (!armed_o)                act = ACT_CLR;
    else if (temp_key > lim_key) act = ACT_SET;
    else if (temp_key < rel_key) act = ACT_CLR;
    else                         act = ACT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
    end else if (vld_i) begin
      case (act)
        ACT_SET: trip_q <= 1'b1;
        ACT_CLR: trip_q <= 1'b0;
        default: trip_q <= trip_q;
      endcase
    end
  end

  assign trip_o = trip_q;

endmodule

// File: rtl/ovb_duty_sel.sv
module ovb_duty_sel #(
  parameter int DW = 8
) (
  input  logic          boost_i,
  input  logic [DW-1:0] req_i,
  input  logic [DW-1:0] max_i,
  output logic [DW-1:0] duty_o
);

  assign duty_o = boost_i ? max_i : req_i;

endmodule

// File: rtl/ovb_top.sv
module ovb_top
  import ovb_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int NUM_FAN = 3,
  parameter int TW      = 8,
  parameter int HW      = 4,
  parameter int DW      = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fmt_twos_i,
  input  logic                  boost_dis_i,
  input  logic [NUM_CH-1:0]     ch_mask_i,
  input  logic [NUM_CH*TW-1:0]  temp_i,
  input  logic [NUM_CH-1:0]     temp_vld_i,
  input  logic [NUM_CH*TW-1:0]  limit_i,
  input  logic [NUM_CH*HW-1:0]  hyst_i,
  input  logic [NUM_FAN*DW-1:0] duty_req_i,
  input  logic [NUM_FAN*DW-1:0] duty_max_i,
  output logic [NUM_FAN*DW-1:0] duty_o,
  output logic [NUM_CH-1:0]     trip_o
);

  tfmt_e             fmt;
  logic [NUM_CH-1:0] armed;
  logic              boost;

  assign fmt = tfmt_e'(fmt_twos_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ovb_chan #(.TW(TW), .HW(HW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fmt_i   (fmt),
      .temp_i  (temp_i[c*TW +: TW]),
      .vld_i   (temp_vld_i[c]),
      .limit_i (limit_i[c*TW +: TW]),
      .hyst_i  (hyst_i[c*HW +: HW]),
      .armed_o (armed[c]),
      .trip_o  (trip_o[c])
    );
  end

  assign boost = !boost_dis_i && |(trip_o & armed & ~ch_mask_i);

  for (genvar k = 0; k < NUM_FAN; k++) begin : g_fan
    ovb_duty_sel #(.DW(DW)) u_sel (
      .boost_i (boost),
      .req_i   (duty_req_i[k*DW +: DW]),
      .max_i   (duty_max_i[k*DW +: DW]),
      .duty_o  (duty_o[k*DW +: DW])
    );
  end

endmodule

// File: rtl/ovb_chk.sv
module ovb_chk #(
  parameter int NUM_CH  = 3,
  parameter int NUM_FAN = 3,
  parameter int TW      = 8,
  parameter int DW      = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  fmt_twos_i,
  input logic                  boost_dis_i,
  input logic [NUM_CH-1:0]     ch_mask_i,
  input logic [NUM_CH*TW-1:0]  temp_i,
  input logic [NUM_CH-1:0]     temp_vld_i,
  input logic [NUM_CH*TW-1:0]  limit_i,
  input logic [NUM_FAN*DW-1:0] duty_req_i,
  input logic [NUM_FAN*DW-1:0] duty_max_i,
  input logic [NUM_FAN*DW-1:0] duty_o,
  input logic [NUM_CH-1:0]     trip_o
);

  logic [NUM_CH-1:0] off_code, above, live;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      logic [TW-1:0] t, l;
      t = limit_i[c*TW +: TW];
      l = temp_i[c*TW +: TW];
      off_code[c] = fmt_twos_i ? (t == {1'b1, {(TW-1){1'b0}}}) : (t == '0);
      above[c]    = fmt_twos_i ? ($signed(l) > $signed(t)) : (l > t);
      live[c]     = trip_o[c] && !off_code[c] && !ch_mask_i[c];
    end
  end

  assert_pass_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live == '0) |-> (duty_o == duty_req_i));

  assert_force_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((live != '0) && !boost_dis_i) |-> (duty_o == duty_max_i));

  assert_dis_pass_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boost_dis_i |-> (duty_o == duty_req_i));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_set_above_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (temp_vld_i[c] && !off_code[c] && above[c]) |=> trip_o[c]);

    assert_hold_no_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !temp_vld_i[c] |=> $stable(trip_o[c]));

    assert_off_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (temp_vld_i[c] && off_code[c]) |=> !trip_o[c]);

    assert_no_set_at_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (temp_vld_i[c] && !above[c] && !trip_o[c]) |=> !trip_o[c]);
  end

endmodule

bind ovb_top ovb_chk #(
  .NUM_CH (NUM_CH),
  .NUM_FAN(NUM_FAN),
  .TW     (TW),
  .DW     (DW)
) u_chk (.*);

// File: tb/tb_ovb_top.sv
module tb_ovb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  typedef struct packed {
    logic       fmt;
    logic       dis;
    logic [2:0] mask;
    logic [2:0] vld;
    logic [7:0] t0, t1, t2;
    logic [7:0] l0, l1, l2;
    logic [3:0] h0, h1, h2;
    logic [2:0] etrip;
    logic       eboost;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t mk(input logic fmt, input logic dis,
                              input logic [2:0] mask, input logic [2:0] vld,
                              input logic [7:0] t0, input logic [7:0] t1, input logic [7:0] t2,
                              input logic [7:0] l0, input logic [7:0] l1, input logic [7:0] l2,
                              input logic [3:0] h0, input logic [3:0] h1, input logic [3:0] h2,
                              input logic [2:0] etrip, input logic eboost, input logic [3:0] rq);
    vec_t v;
    v.fmt = fmt; v.dis = dis; v.mask = mask; v.vld = vld;
    v.t0 = t0; v.t1 = t1; v.t2 = t2;
    v.l0 = l0; v.l1 = l1; v.l2 = l2;
    v.h0 = h0; v.h1 = h1; v.h2 = h2;
    v.etrip = etrip; v.eboost = eboost; v.rq = rq;
    return v;
  endfunction

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    mk(0,0,3'b000,3'b111,8'h50,8'h50,8'h50,8'h64,8'h64,8'h64,4,4,4,3'b000,0,2),  // R2
    mk(0,0,3'b000,3'b001,8'h64,8'h50,8'h50,8'h64,8'h64,8'h64,4,4,4,3'b000,0,4),  // R4
    mk(0,0,3'b000,3'b001,8'h65,8'h50,8'h50,8'h64,8'h64,8'h64,4,4,4,3'b001,1,3),  // R3
    mk(0,0,3'b000,3'b001,8'h60,8'h50,8'h50,8'h64,8'h64,8'h64,4,4,4,3'b001,1,5),  // R5
    mk(0,0,3'b000,3'b010,8'h10,8'h90,8'h50,8'h64,8'h64,8'h64,4,4,4,3'b011,1,6),  // R6
    mk(0,0,3'b000,3'b001,8'h5F,8'h90,8'h50,8'h64,8'h64,8'h64,4,4,4,3'b010,1,5),  // R5
    mk(0,0,3'b000,3'b010,8'h5F,8'h10,8'h50,8'h64,8'h64,8'h64,4,4,4,3'b000,0,5),  // R5
    mk(0,0,3'b000,3'b100,8'h5F,8'h10,8'hC0,8'h64,8'h64,8'h64,4,4,4,3'b100,1,7),  // R7
    mk(0,0,3'b100,3'b000,8'h5F,8'h10,8'hC0,8'h64,8'h64,8'h64,4,4,4,3'b100,0,13), // R13
    mk(0,1,3'b000,3'b000,8'h5F,8'h10,8'hC0,8'h64,8'h64,8'h64,4,4,4,3'b100,0,12), // R12
    mk(0,0,3'b000,3'b000,8'h5F,8'h10,8'hC0,8'h64,8'h64,8'h64,4,4,4,3'b100,1,3),  // R3
    mk(0,0,3'b000,3'b000,8'h5F,8'h10,8'hC0,8'h64,8'h64,8'h00,4,4,4,3'b100,0,9),  // R9
    mk(0,0,3'b000,3'b100,8'h5F,8'h10,8'hC0,8'h64,8'h64,8'h00,4,4,4,3'b000,0,9),  // R9
    mk(1,0,3'b000,3'b111,8'hF0,8'hF0,8'hF0,8'h64,8'h64,8'h64,4,4,4,3'b000,0,8),  // R8
    mk(1,0,3'b000,3'b001,8'h70,8'hF0,8'hF0,8'h64,8'h64,8'h64,4,4,4,3'b001,1,8),  // R8
    mk(1,0,3'b000,3'b001,8'hFF,8'hF0,8'hF0,8'h64,8'h64,8'h64,4,4,4,3'b000,0,8),  // R8
    mk(1,0,3'b000,3'b010,8'hFF,8'h7F,8'hF0,8'h64,8'h80,8'h64,4,4,4,3'b000,0,10), // R10
    mk(1,0,3'b000,3'b001,8'h85,8'h7F,8'hF0,8'h82,8'h64,8'h64,5,4,4,3'b001,1,3),  // R3
    mk(1,0,3'b000,3'b001,8'h80,8'h7F,8'hF0,8'h82,8'h64,8'h64,5,4,4,3'b001,1,11), // R11
    mk(0,0,3'b000,3'b001,8'h05,8'h7F,8'hF0,8'h02,8'h64,8'h64,5,4,4,3'b001,1,3),  // R3
    mk(0,0,3'b000,3'b001,8'h00,8'h7F,8'hF0,8'h02,8'h64,8'h64,5,4,4,3'b001,1,11), // R11
    mk(0,0,3'b000,3'b001,8'h00,8'h7F,8'hF0,8'h64,8'h64,8'h64,4,4,4,3'b000,0,5),  // R5
    mk(0,0,3'b000,3'b001,8'h65,8'h7F,8'hF0,8'h64,8'h64,8'h64,0,4,4,3'b001,1,3),  // R3
    mk(0,0,3'b000,3'b001,8'h64,8'h7F,8'hF0,8'h64,8'h64,8'h64,0,4,4,3'b001,1,5),  // R5
    mk(0,0,3'b000,3'b001,8'h63,8'h7F,8'hF0,8'h64,8'h64,8'h64,0,4,4,3'b000,0,5)   // R5
  };

  localparam logic [23:0] REQ = 24'h40_30_20;
  localparam logic [23:0] MAX = 24'hFF_F0_E0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fmt_twos_i = 1'b0;
  logic        boost_dis_i = 1'b0;
  logic [2:0]  ch_mask_i = '0;
  logic [23:0] temp_i = '0;
  logic [2:0]  temp_vld_i = '0;
  logic [23:0] limit_i = {3{8'h64}};
  logic [11:0] hyst_i = {3{4'd4}};
  logic [23:0] duty_req_i = REQ;
  logic [23:0] duty_max_i = MAX;
  logic [23:0] duty_o;
  logic [2:0]  trip_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovb_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_twos_i(fmt_twos_i), .boost_dis_i(boost_dis_i),
    .ch_mask_i(ch_mask_i), .temp_i(temp_i), .temp_vld_i(temp_vld_i), .limit_i(limit_i),
    .hyst_i(hyst_i), .duty_req_i(duty_req_i), .duty_max_i(duty_max_i),
    .duty_o(duty_o), .trip_o(trip_o)
  );

  task automatic chk_trip(input string rq, input logic [2:0] exp);
    checks++;
    if (trip_o !== exp) begin
      failures++;
      $display("FAIL %s trip_o act=%b exp=%b", rq, trip_o, exp);
    end
  endtask

  task automatic chk_duty(input string rq, input logic boost);
    logic [23:0] exp;
    exp = boost ? MAX : REQ;
    checks++;
    if (duty_o !== exp) begin
      failures++;
      $display("FAIL %s duty_o act=%h exp=%h", rq, duty_o, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*2);
    chk_trip("R1", 3'b000);
    chk_duty("R1", 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v.rq, i);
      @(negedge clk);
      fmt_twos_i  = v.fmt;
      boost_dis_i = v.dis;
      ch_mask_i   = v.mask;
      temp_vld_i  = v.vld;
      temp_i      = {v.t2, v.t1, v.t0};
      limit_i     = {v.l2, v.l1, v.l0};
      hyst_i      = {v.h2, v.h1, v.h0};
      @(posedge clk);
      @(negedge clk);
      temp_vld_i = '0;
      chk_trip(tag, v.etrip);
      chk_duty(tag, v.eboost);
    end

    // R12: latch still updates with boost disabled
    fmt_twos_i = 1'b0; limit_i = {3{8'h64}}; hyst_i = {3{4'd4}};
    boost_dis_i = 1'b1; temp_i = {8'h00, 8'h00, 8'h70}; temp_vld_i = 3'b001;
    @(posedge clk); @(negedge clk);
    temp_vld_i = '0;
    chk_trip("R12", 3'b001);
    chk_duty("R12", 1'b0);
    boost_dis_i = 1'b0;
    #1;
    chk_duty("R3", 1'b1);

    // R1: reset in the middle of a trip
    rst_ni = 1'b0;
    #1;
    chk_trip("R1", 3'b000);
    chk_duty("R1", 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_trip("R1", 3'b000);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=running exp=done");
      summary();
    end
  end

endmodule